// File: doc/BRIEF.md
# Window Watchdog with Reset Generator

This block supervises a host microcontroller. It drives an active-low reset to the host and watches a trigger input for rising edges. All timing comes from a single-cycle tick input, which stands for one period of a slow trimmed oscillator. Every interval is a parameter counted in ticks.

After power-on, the reset output is held asserted for a long start-up interval. It is then released, and the block opens a lead-in window in which the host must deliver its first trigger edge. An accepted first edge raises a sync flag and starts a repeating pair of windows: a closed window, in which any edge is an error, and an open window, in which exactly one edge is expected.

- An edge in the open window re-arms the pair.
- An early edge (in the closed window) or a missing edge (open window expires) produces a short reset pulse, followed by a fresh lead-in window.
- A lead-in window that expires without an edge repeats the long start-up reset.
- A supply-low input forces reset for as long as it is active, and the full start-up sequence follows its release.

Top module: `wdg_supervisor`

## Requirements
- R1: While `rst_n` is low, and afterwards for POR_TICKS ticks, `rst_n_o` is 0 (reset asserted) and `sync_o` is 0.
- R2: After the start-up reset is released, `rst_n_o` stays 1 for LEAD_TICKS ticks while the block waits for a first edge. An edge in that window is accepted and sets `sync_o` to 1.
- R3: If the lead-in window ends without an edge, `rst_n_o` returns to 0 for POR_TICKS ticks, and then another lead-in window follows.
- R4: After an accepted edge, a closed window of CLOSED_TICKS ticks is followed by an open window of OPEN_TICKS ticks. An edge in the open window, including in the cycle its last tick arrives, restarts the closed window and `rst_n_o` stays 1.
- R5: An edge during the closed window asserts a short reset: `rst_n_o` is 0 for SHORT_TICKS ticks.
- R6: If the open window ends without an edge, a short reset of SHORT_TICKS ticks follows.
- R7: A short reset is followed by a full lead-in window of LEAD_TICKS ticks, with the same rules as after power-on.
- R8: While `supply_low_i` is 1, `rst_n_o` is 0 from the next clock on. After `supply_low_i` returns to 0, a full POR_TICKS start-up interval is counted.
- R9: `sync_o` is 1 only while `rst_n_o` is 1. It clears in the same clock edge in which reset is asserted for any reason.
- R10: `trig_i` passes through two synchronizer flops. A rise acts at the third clock edge after it is first sampled. Edges that act during a reset interval are ignored.
- R11: An edge that acts in the same cycle as the final tick of the lead-in window is accepted. It is not treated as an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_i | input | 1 | One-cycle timebase pulse, one per oscillator period |
| trig_i | input | 1 | Asynchronous trigger from the host; rising edges count |
| supply_low_i | input | 1 | High while the host supply is below its threshold |
| rst_n_o | output | 1 | Active-low reset to the host |
| sync_o | output | 1 | High once a first trigger has been accepted since the last reset |

## Verification
Two functions can coincide in one clock. A trigger edge can act in the same cycle as the tick that ends the lead-in window, and a trigger edge can act in the cycle whose tick ends the open window; in both cases the edge must take priority over expiry. The bench provokes these coincidences with a tick every third clock. It sweeps the trigger rise one clock at a time across the whole lead-in window and across the closed/open pair, so that every alignment of edge and final tick occurs. A behavioural model compares the reset and sync outputs with the design on every clock.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [2:0] {
    PH_POR    = 3'd0,
    PH_LEAD   = 3'd1,
    PH_CLOSED = 3'd2,
    PH_OPEN   = 3'd3,
    PH_SHORT  = 3'd4
  } wdg_phase_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wdg_edge_sync.sv
module wdg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  output logic rise_o
);

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], din_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R10: a detected rise lasts exactly one clock
  p_rise_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/wdg_interval_timer.sv
module wdg_interval_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;

  assign done_o = tick_i && (cnt_q == limit_i - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= done_o ? '0 : cnt_q + ONE;
  end

  // R4: the shared count never passes the limit of the running interval
  p_count_below_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < limit_i);

endmodule

// File: rtl/wdg_phase_ctrl.sv
module wdg_phase_ctrl
  import wdg_pkg::*;
#(
  parameter int CW       = 8,
  parameter int POR_T    = 8,
  parameter int LEAD_T   = 8,
  parameter int CLOSED_T = 8,
  parameter int OPEN_T   = 8,
  parameter int SHORT_T  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_low_i,
  input  logic          rise_i,
  input  logic          done_i,
  output logic          clear_o,
  output logic [CW-1:0] limit_o,
  output logic          release_o,
  output logic          sync_o
);

  localparam logic [CW-1:0] L_POR    = CW'(POR_T);
  localparam logic [CW-1:0] L_LEAD   = CW'(LEAD_T);
  localparam logic [CW-1:0] L_CLOSED = CW'(CLOSED_T);
  localparam logic [CW-1:0] L_OPEN   = CW'(OPEN_T);
  localparam logic [CW-1:0] L_SHORT  = CW'(SHORT_T);

  wdg_phase_e phase_q, phase_d;
  logic       sync_q, sync_d;
  logic       rel_q, rel_d;

  always_comb begin
    phase_d = phase_q;
    sync_d  = sync_q;
    if (supply_low_i) begin
      phase_d = PH_POR;
      sync_d  = 1'b0;
    end else begin
      unique case (phase_q)
        PH_POR: if (done_i) phase_d = PH_LEAD;
        PH_LEAD: begin
          if (rise_i) begin
            phase_d = PH_CLOSED;
            sync_d  = 1'b1;
          end else if (done_i) begin
            phase_d = PH_POR;
          end
        end
        PH_CLOSED: begin
          if (rise_i) begin
            phase_d = PH_SHORT;
            sync_d  = 1'b0;
          end else if (done_i) begin
            phase_d = PH_OPEN;
          end
        end
        PH_OPEN: begin
          if (rise_i) begin
            phase_d = PH_CLOSED;
          end else if (done_i) begin
            phase_d = PH_SHORT;
            sync_d  = 1'b0;
          end
        end
        PH_SHORT: if (done_i) phase_d = PH_LEAD;
        default: begin
          phase_d = PH_POR;
          sync_d  = 1'b0;
        end
      endcase
    end
  end

  assign rel_d   = (phase_d == PH_LEAD) || (phase_d == PH_CLOSED) || (phase_d == PH_OPEN);
  assign clear_o = supply_low_i || (phase_d != phase_q);

  always_comb begin
    unique case (phase_q)
      PH_LEAD:   limit_o = L_LEAD;
      PH_CLOSED: limit_o = L_CLOSED;
      PH_OPEN:   limit_o = L_OPEN;
      PH_SHORT:  limit_o = L_SHORT;
      default:   limit_o = L_POR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_POR;
      sync_q  <= 1'b0;
      rel_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      sync_q  <= sync_d;
      rel_q   <= rel_d;
    end
  end

  assign release_o = rel_q;
  assign sync_o    = sync_q;

  // R3: lead-in expiry without an edge returns to the long reset
  p_lead_expiry_por_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LEAD && done_i && !rise_i && !supply_low_i) |=> (phase_q == PH_POR));

  // R11: an edge on the final lead-in tick is accepted
  p_lead_edge_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LEAD && rise_i && !supply_low_i) |=> (phase_q == PH_CLOSED && sync_o));

  // R5: an early edge ends in a short reset
  p_closed_edge_fails_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CLOSED && rise_i && !supply_low_i) |=> (phase_q == PH_SHORT && !release_o));

  // R4: an edge inside the open window re-arms the closed window
  p_open_edge_rearms_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_OPEN && rise_i && !supply_low_i) |=> (phase_q == PH_CLOSED && release_o));

  // R6: an open window without an edge ends in a short reset
  p_open_expiry_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_OPEN && done_i && !rise_i && !supply_low_i) |=> (phase_q == PH_SHORT));

  // R7: the short reset hands over to a lead-in window
  p_short_to_lead_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SHORT && done_i && !supply_low_i) |=> (phase_q == PH_LEAD && release_o));

endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
  import wdg_pkg::*;
#(
  parameter int POR_TICKS    = 5520,
  parameter int LEAD_TICKS   = 5520,
  parameter int CLOSED_TICKS = 980,
  parameter int OPEN_TICKS   = 780,
  parameter int SHORT_TICKS  = 162,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic trig_i,
  input  logic supply_low_i,
  output logic rst_n_o,
  output logic sync_o
);

  localparam int MAX_T = max_of(max_of(max_of(POR_TICKS, LEAD_TICKS),
                                       max_of(CLOSED_TICKS, OPEN_TICKS)), SHORT_TICKS);
  localparam int CW    = $clog2(MAX_T + 1);

  logic          rise;
  logic          done;
  logic          clear;
  logic [CW-1:0] limit;

  wdg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_i  (trig_i),
    .rise_o (rise)
  );

  wdg_interval_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (clear),
    .tick_i  (tick_i),
    .limit_i (limit),
    .done_o  (done)
  );

  wdg_phase_ctrl #(
    .CW       (CW),
    .POR_T    (POR_TICKS),
    .LEAD_T   (LEAD_TICKS),
    .CLOSED_T (CLOSED_TICKS),
    .OPEN_T   (OPEN_TICKS),
    .SHORT_T  (SHORT_TICKS)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_low_i (supply_low_i),
    .rise_i       (rise),
    .done_i       (done),
    .clear_o      (clear),
    .limit_o      (limit),
    .release_o    (rst_n_o),
    .sync_o       (sync_o)
  );

  // R8: a low supply holds the host in reset from the next clock on
  p_supply_holds_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(supply_low_i) |-> (!rst_n_o && !sync_o));

  // R9: the sync flag is never shown while the host is in reset
  p_sync_needs_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> rst_n_o);

endmodule

// File: tb/wdg_supervisor_tb_top.sv
module wdg_supervisor_tb_top;

  localparam int POR = 6;
  localparam int LEAD = 8;
  localparam int CL = 10;
  localparam int OP = 8;
  localparam int SH = 3;

  logic clk = 1'b0;
  logic rst_n, tick_i, trig_i, supply_low_i;
  logic rst_n_o, sync_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int tdiv = 1;
  int tc = 0;
  string cur_tag = "R1";

  // model state: 0 por, 1 lead, 2 closed, 3 open, 4 short
  int m_ph = 0;
  int m_cnt = 0;
  int m_sync = 0;
  int q1 = 0, q2 = 0, q3 = 0;

  always #2 clk = ~clk;

  wdg_supervisor #(
    .POR_TICKS(POR), .LEAD_TICKS(LEAD), .CLOSED_TICKS(CL),
    .OPEN_TICKS(OP), .SHORT_TICKS(SH), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .trig_i(trig_i),
    .supply_low_i(supply_low_i), .rst_n_o(rst_n_o), .sync_o(sync_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int lim(input int ph);
    case (ph)
      1: return LEAD;
      2: return CL;
      3: return OP;
      4: return SH;
      default: return POR;
    endcase
  endfunction

  // tick generator
  always @(negedge clk) begin
    if (tdiv <= 1) tick_i <= 1'b1;
    else begin
      tick_i <= (tc == 0);
      tc = (tc + 1) % tdiv;
    end
  end

  // behavioural reference
  always @(posedge clk) begin
    int ev, dn, old;
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_sync = 0; q1 = 0; q2 = 0; q3 = 0;
    end else begin
      ev = (q2 == 1 && q3 == 0) ? 1 : 0;
      dn = (tick_i && m_cnt == lim(m_ph) - 1) ? 1 : 0;
      old = m_ph;
      if (supply_low_i) begin
        m_ph = 0; m_sync = 0;
      end else begin
        case (m_ph)
          0: if (dn == 1) m_ph = 1;
          1: if (ev == 1) begin m_ph = 2; m_sync = 1; end else if (dn == 1) m_ph = 0;
          2: if (ev == 1) begin m_ph = 4; m_sync = 0; end else if (dn == 1) m_ph = 3;
          3: if (ev == 1) m_ph = 2; else if (dn == 1) begin m_ph = 4; m_sync = 0; end
          default: if (dn == 1) m_ph = 1;
        endcase
      end
      if (supply_low_i || m_ph != old) m_cnt = 0;
      else if (tick_i) m_cnt = (dn == 1) ? 0 : m_cnt + 1;
      q3 = q2; q2 = q1; q1 = int'(trig_i);
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_tag, int'(rst_n_o), (m_ph >= 1 && m_ph <= 3) ? 1 : 0);
      chk(cur_tag, int'(sync_o), m_sync);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run_here(input int lvl, output int n);
    n = 0;
    while (int'(rst_n_o) == lvl) begin n++; @(negedge clk); end
  endtask

  task automatic measure(input int lvl, output int n);
    @(negedge clk);
    while (int'(rst_n_o) != lvl) @(negedge clk);
    run_here(lvl, n);
  endtask

  task automatic pulse();
    trig_i = 1'b1; @(negedge clk); @(negedge clk); trig_i = 1'b0; @(negedge clk);
  endtask

  task automatic restart();
    supply_low_i = 1'b1; @(negedge clk); @(negedge clk); supply_low_i = 1'b0;
    @(negedge clk);
    while (m_ph != 1) @(negedge clk);
  endtask

  initial begin
    int n;
    rst_n = 1'b0; trig_i = 1'b0; supply_low_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1", int'(rst_n_o), 0);
    chk("R1", int'(sync_o), 0);
    rst_n = 1'b1;
    cur_tag = "R1";
    measure(1, n);
    chk("R2", n, LEAD);
    cur_tag = "R3";
    run_here(0, n);
    chk("R3", n, POR);
    // lead-in start (k=0): first trigger
    cur_tag = "R2";
    trig_i = 1'b1; @(negedge clk); @(negedge clk); trig_i = 1'b0;
    @(negedge clk);
    chk("R2", int'(sync_o), 1);
    // hit the open window
    cur_tag = "R4";
    repeat (CL - 1) @(negedge clk);
    trig_i = 1'b1; @(negedge clk); @(negedge clk); trig_i = 1'b0;
    repeat (OP) @(negedge clk);
    chk("R4", int'(rst_n_o), 1);
    // no more triggers: open expiry
    cur_tag = "R6";
    measure(0, n);
    chk("R6", n, SH);
    chk("R9", int'(sync_o), 0);
    cur_tag = "R7";
    run_here(1, n);
    chk("R7", n, LEAD);
    run_here(0, n);
    // early trigger in the closed window
    cur_tag = "R5";
    trig_i = 1'b1; @(negedge clk); @(negedge clk); trig_i = 1'b0;
    @(negedge clk); @(negedge clk);
    trig_i = 1'b1; @(negedge clk); @(negedge clk); trig_i = 1'b0;
    measure(0, n);
    chk("R5", n, SH);
    // supply low during normal operation
    cur_tag = "R8";
    trig_i = 1'b1; @(negedge clk); @(negedge clk); trig_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2", int'(sync_o), 1);
    supply_low_i = 1'b1;
    @(negedge clk);
    chk("R8", int'(rst_n_o), 0);
    chk("R9", int'(sync_o), 0);
    @(negedge clk);
    supply_low_i = 1'b0;
    // edge acting inside the start-up reset is ignored
    cur_tag = "R10";
    trig_i = 1'b1; @(negedge clk); @(negedge clk); trig_i = 1'b0;
    measure(1, n);
    chk("R10", n, LEAD);
    // slower tick; sweep edge across closed and open windows
    tdiv = 3;
    cur_tag = "R4";
    for (int d = 0; d < (CL + OP) * 3 + 6; d++) begin
      restart();
      pulse();
      while (m_ph != 2) @(negedge clk);
      repeat (d) @(negedge clk);
      pulse();
      repeat (24) @(negedge clk);
    end
    // sweep edge across the lead-in window end
    cur_tag = "R11";
    for (int d = 0; d < LEAD * 3 + 6; d++) begin
      restart();
      repeat (d) @(negedge clk);
      pulse();
      repeat (30) @(negedge clk);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule